// File: doc/BRIEF.md
# Remote Transmission Session Controller

This block sequences the code words of a button-operated keyless-entry transmitter. It watches four debounced button lines and decides when a code word begins, when another follows, when the one in flight is cut short, and when the radio is switched off. A serializer outside the block sends each word. It is told to begin by a one-cycle `word_start` pulse. It answers with a one-cycle `word_done` pulse once the word and the guard gap after it have finished. It stops at once when it sees `word_abort`.

For each activation the block chooses between a rolling (hopping) word and a fixed seed word. Seed words are requested either by an immediate button combination or by holding a second combination for a delay. They can be restricted to the early life of the synchronization counter. The block also keeps two status fields that travel in every word. One is a saturating repeat-press counter. The other is a saturating hold-duration counter. It asks the external synchronization counter to step once for each rolling activation. All intervals are counted in strobes of a single `tick` input and set by parameters, so the same RTL serves real time bases and short test runs.

Top module: `tx_session_ctrl`

## Requirements
- R1: After reset, `rf_en`, `word_start`, `word_abort`, `sync_inc` and `asleep` are 0, and `queue_bits` and `time_bits` are 00.
- R2: A non-zero `btn` seen while idle starts an activation. `rf_en` rises at least one cycle before `word_start` and stays high during every word. For a rolling word, `word_func` equals the buttons latched at activation, and `sync_inc` pulses exactly once.
- R3: Once every button has been released, words continue until the count sent in this activation reaches the minimum set by `cfg_min_words`: 00=1, 01=2, 10=4, 11=8.
- R4: `cfg_timeout` sets the session limit, counted in ticks from activation: 00=none, 01=1 unit, 10=4 units, 11=32 units. On expiry the word in flight is aborted, `rf_en` drops and `asleep` holds until all buttons are released.
- R5: The time-out takes priority over the minimum word count.
- R6: A button not in the latched combination, pressed while a word is in flight, aborts that word. It also starts a new activation (new function code, new `sync_inc`, time-out restarted) with `queue_bits` 00.
- R7: Releasing only some of the latched buttons changes neither the function code nor the word sequence.
- R8: `queue_bits` goes up by one, saturating at 11, when the same combination is pressed again after a full release. This counts while the final words are still being sent (the word in flight is aborted) or within the repeat window after the last word. In the window, buttons are sampled once every `SAMPLE_TICKS`. A different combination, or a press after the window, gives 00.
- R9: `time_bits` restarts at 00 on each activation and advances once per unit of ticks while buttons are held, saturating at 11.
- R10: An immediate seed word is sent for combination 0101 (`cfg_seed_alt`=0) or 1001 (`cfg_seed_alt`=1). Seed words carry `word_seed`=1 and `word_func`=1111, and they cause no `sync_inc`.
- R11: Holding combination 0001 for 2 units (`cfg_seed_alt`=0), or 0011 for 4 units (`cfg_seed_alt`=1), turns the following words of that activation into seed words.
- R12: `cfg_seed_mode`: 00 disables seed words. 01 allows both kinds only while `sync_cnt` is 0x0000 to 0x007F. 10 allows both always. 11 allows only the immediate kind.
- R13: `rf_en` returns low in the cycle after the last `word_done` of a session, or on a time-out, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe, one cycle wide |
| btn | input | 4 | Debounced button levels |
| word_done | input | 1 | Serializer finished a word and its guard gap |
| cfg_timeout | input | 2 | Session time-out select |
| cfg_min_words | input | 2 | Minimum words after release |
| cfg_seed_mode | input | 2 | Seed word policy |
| cfg_seed_alt | input | 1 | Selects the alternate seed combinations and delay |
| sync_cnt | input | 16 | Current synchronization counter value |
| rf_en | output | 1 | Transmitter enable |
| word_start | output | 1 | Pulse: serializer begins a word |
| word_abort | output | 1 | Pulse: serializer drops the word in flight |
| word_seed | output | 1 | Current word is a seed word |
| word_func | output | 4 | Function code for the current word |
| sync_inc | output | 1 | Pulse: step the synchronization counter |
| queue_bits | output | 2 | Repeat-press status |
| time_bits | output | 2 | Hold-duration status |
| asleep | output | 1 | Stopped by time-out, waiting for full release |

## Verification
The bench builds the block with a unit of 16 ticks, a repeat window of 40 ticks and a sampling period of 4 ticks, and it drives `tick` every cycle. With these values the one-unit time-out falls inside the second word. The two-unit and four-unit seed delays and the saturation of both status counters take only a few dozen cycles. The whole repeat window, with several samples in it, fits between two presses. A serializer model with a 10-cycle word lets the bench count starts, aborts and counter steps in every session.

// File: rtl/tx_sess_pkg.sv
package tx_sess_pkg;

    localparam int NBTN = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XMIT,
        ST_QWAIT,
        ST_SLEEP
    } sess_state_e;

    typedef enum logic [1:0] {
        SEED_OFF      = 2'b00,
        SEED_LIMITED  = 2'b01,
        SEED_FULL     = 2'b10,
        SEED_IMM_ONLY = 2'b11
    } seed_mode_e;

    typedef struct packed {
        logic [1:0] timeout;
        logic [1:0] min_words;
        seed_mode_e seed_mode;
        logic       seed_alt;
    } sess_cfg_t;

    function automatic logic [3:0] min_word_count(input logic [1:0] sel);
        return 4'd1 << sel;
    endfunction

    function automatic logic [5:0] timeout_units(input logic [1:0] sel);
        case (sel)
            2'b01:   return 6'd1;
            2'b10:   return 6'd4;
            2'b11:   return 6'd32;
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic [NBTN-1:0] imm_seed_combo(input logic alt);
        return alt ? 4'b1001 : 4'b0101;
    endfunction

    function automatic logic [NBTN-1:0] dly_seed_combo(input logic alt);
        return alt ? 4'b0011 : 4'b0001;
    endfunction

    function automatic logic [2:0] dly_seed_units(input logic alt);
        return alt ? 3'd4 : 3'd2;
    endfunction

    function automatic logic [1:0] sat_inc2(input logic [1:0] v);
        return (v == 2'b11) ? v : v + 2'd1;
    endfunction

endpackage

// File: rtl/tx_tick_div.sv
module tx_tick_div #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic wrap
);
    localparam int W = $clog2(PERIOD + 1);
    localparam logic [W-1:0] LAST = W'(PERIOD - 1);

    logic [W-1:0] cnt;

    assign wrap = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tx_sat_cnt.sv
module tx_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            value <= '0;
        end else if (inc && (value != {W{1'b1}})) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/tx_seed_pick.sv
module tx_seed_pick
    import tx_sess_pkg::*;
(
    input  logic [NBTN-1:0] btn,
    input  logic [NBTN-1:0] cur_btn,
    input  sess_cfg_t       cfg,
    input  logic [15:0]     sync_cnt,
    input  logic [2:0]      units,
    output logic            imm_seed,
    output logic            dly_seed
);
    logic young;
    logic imm_allow;
    logic dly_allow;

    always_comb begin
        young     = (sync_cnt[15:7] == '0);
        imm_allow = 1'b0;
        dly_allow = 1'b0;
        case (cfg.seed_mode)
            SEED_LIMITED: begin
                imm_allow = young;
                dly_allow = young;
            end
            SEED_FULL: begin
                imm_allow = 1'b1;
                dly_allow = 1'b1;
            end
            SEED_IMM_ONLY: imm_allow = 1'b1;
            default: ;
        endcase
        imm_seed = imm_allow && (btn == imm_seed_combo(cfg.seed_alt));
        dly_seed = dly_allow && (btn == cur_btn)
                 && (cur_btn == dly_seed_combo(cfg.seed_alt))
                 && (units >= dly_seed_units(cfg.seed_alt));
    end
endmodule

// File: rtl/tx_session_ctrl.sv
module tx_session_ctrl
    import tx_sess_pkg::*;
#(
    parameter int UNIT_TICKS   = 8000,
    parameter int QWIN_TICKS   = 20000,
    parameter int SAMPLE_TICKS = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic [3:0]  btn,
    input  logic        word_done,
    input  logic [1:0]  cfg_timeout,
    input  logic [1:0]  cfg_min_words,
    input  logic [1:0]  cfg_seed_mode,
    input  logic        cfg_seed_alt,
    input  logic [15:0] sync_cnt,
    output logic        rf_en,
    output logic        word_start,
    output logic        word_abort,
    output logic        word_seed,
    output logic [3:0]  word_func,
    output logic        sync_inc,
    output logic [1:0]  queue_bits,
    output logic [1:0]  time_bits,
    output logic        asleep
);
    localparam int TO_MAX = 32 * UNIT_TICKS;
    localparam int TO_W   = $clog2(TO_MAX + 1);
    localparam int QW_W   = $clog2(QWIN_TICKS + 1);

    sess_cfg_t       cfg;
    sess_state_e     st;
    logic [NBTN-1:0] cur_btn;
    logic            released;
    logic [3:0]      words_sent;
    logic            seed_now;
    logic [1:0]      queue;

    logic [TO_W-1:0] to_cnt;
    logic [TO_W-1:0] to_limit;
    logic            to_hit;
    logic [2:0]      units;
    logic            unit_wrap;
    logic [QW_W-1:0] qwin_cnt;
    logic            qwin_done;
    logic            samp_wrap;
    logic            in_session;
    logic            btn_any;
    logic            imm_seed;
    logic            dly_seed;
    logic            activate;
    logic            go_abort;
    logic [1:0]      act_queue;
    logic            stop_now;

    assign cfg = '{timeout: cfg_timeout, min_words: cfg_min_words,
                   seed_mode: seed_mode_e'(cfg_seed_mode), seed_alt: cfg_seed_alt};

    assign in_session = (st == ST_LEAD) || (st == ST_XMIT);
    assign btn_any    = (btn != '0);

    // Session time-out: ticks since activation
    tx_sat_cnt #(.W(TO_W)) u_to_cnt (
        .clk(clk), .rst(rst), .clr(activate),
        .inc(tick && in_session), .value(to_cnt)
    );

    assign to_limit = TO_W'(timeout_units(cfg.timeout)) * TO_W'(UNIT_TICKS);
    assign to_hit   = (cfg.timeout != 2'b00) && (to_cnt >= to_limit);

    // Hold duration in units
    tx_tick_div #(.PERIOD(UNIT_TICKS)) u_unit_div (
        .clk(clk), .rst(rst), .clr(activate),
        .en(tick && in_session && btn_any), .wrap(unit_wrap)
    );

    tx_sat_cnt #(.W(3)) u_units (
        .clk(clk), .rst(rst), .clr(activate),
        .inc(unit_wrap), .value(units)
    );

    // Repeat window after the last word, with its sampling strobe
    tx_sat_cnt #(.W(QW_W)) u_qwin (
        .clk(clk), .rst(rst), .clr(st != ST_QWAIT),
        .inc(tick && (st == ST_QWAIT)), .value(qwin_cnt)
    );

    assign qwin_done = (qwin_cnt >= QW_W'(QWIN_TICKS));

    tx_tick_div #(.PERIOD(SAMPLE_TICKS)) u_samp_div (
        .clk(clk), .rst(rst), .clr(st != ST_QWAIT),
        .en(tick && (st == ST_QWAIT)), .wrap(samp_wrap)
    );

    tx_seed_pick u_seed (
        .btn(btn), .cur_btn(cur_btn), .cfg(cfg), .sync_cnt(sync_cnt),
        .units(units), .imm_seed(imm_seed), .dly_seed(dly_seed)
    );

    // Activation decisions
    always_comb begin
        activate  = 1'b0;
        go_abort  = 1'b0;
        act_queue = 2'b00;
        stop_now  = (released || !btn_any)
                  && (words_sent >= min_word_count(cfg.min_words));
        case (st)
            ST_IDLE: activate = btn_any;
            ST_QWAIT: begin
                if (samp_wrap && btn_any) begin
                    activate  = 1'b1;
                    act_queue = (btn == cur_btn) ? sat_inc2(queue) : 2'b00;
                end
            end
            ST_XMIT: begin
                if (!to_hit) begin
                    if (released ? btn_any : ((btn & ~cur_btn) != '0)) begin
                        activate  = 1'b1;
                        go_abort  = 1'b1;
                        act_queue = (released && (btn == cur_btn))
                                  ? sat_inc2(queue) : 2'b00;
                    end
                end
            end
            default: ;
        endcase
    end

    // Session state
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            cur_btn    <= '0;
            released   <= 1'b0;
            words_sent <= '0;
            seed_now   <= 1'b0;
            queue      <= 2'b00;
            word_start <= 1'b0;
            word_abort <= 1'b0;
            sync_inc   <= 1'b0;
        end else begin
            word_start <= 1'b0;
            word_abort <= go_abort;
            sync_inc   <= 1'b0;
            if (activate) begin
                st         <= ST_LEAD;
                cur_btn    <= btn;
                queue      <= act_queue;
                words_sent <= '0;
                released   <= 1'b0;
                seed_now   <= imm_seed;
                sync_inc   <= !imm_seed;
            end else begin
                case (st)
                    ST_LEAD: begin
                        st         <= ST_XMIT;
                        word_start <= 1'b1;
                        if (words_sent != 4'hF) words_sent <= words_sent + 4'd1;
                        if (dly_seed) seed_now <= 1'b1;
                    end
                    ST_XMIT: begin
                        if (to_hit) begin
                            word_abort <= 1'b1;
                            st         <= ST_SLEEP;
                        end else begin
                            if (!btn_any) released <= 1'b1;
                            if (word_done) st <= stop_now ? ST_QWAIT : ST_LEAD;
                        end
                    end
                    ST_QWAIT: begin
                        if (qwin_done) begin
                            st    <= ST_IDLE;
                            queue <= 2'b00;
                        end
                    end
                    ST_SLEEP: begin
                        queue <= 2'b00;
                        if (!btn_any) st <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign rf_en      = in_session;
    assign asleep     = (st == ST_SLEEP);
    assign word_seed  = seed_now;
    assign word_func  = seed_now ? 4'hF : cur_btn;
    assign queue_bits = queue;
    assign time_bits  = (units >= 3'd3) ? 2'b11 : units[1:0];

endmodule

// File: rtl/tx_session_ctrl_chk.sv
module tx_session_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       word_done,
    input logic       rf_en,
    input logic       word_start,
    input logic       word_abort,
    input logic       word_seed,
    input logic [3:0] word_func,
    input logic [1:0] queue_bits,
    input logic [1:0] time_bits,
    input logic       asleep
);
    // R2: a word never starts in the first cycle of rf_en
    p_lead_r2: assert property (@(posedge clk) disable iff (rst)
        word_start |-> (rf_en && $past(rf_en)));

    // R10: seed words carry function code 1111
    p_seed_func_r10: assert property (@(posedge clk) disable iff (rst)
        (word_start && word_seed) |-> (word_func == 4'hF));

    // R8: queue saturates at 11 and never wraps to 01 or 10
    p_queue_sat_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(queue_bits) == 2'b11) |-> (queue_bits == 2'b11 || queue_bits == 2'b00));

    // R9: duration field steps by at most one
    p_time_step_r9: assert property (@(posedge clk) disable iff (rst)
        (time_bits > $past(time_bits)) |-> (time_bits == $past(time_bits) + 2'd1));

    // R4: asleep means the transmitter is quiet
    p_sleep_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        asleep |-> (!rf_en && !word_start));

    // R6: an abort only follows a cycle with the transmitter on
    p_abort_live_r6: assert property (@(posedge clk) disable iff (rst)
        word_abort |-> $past(rf_en));

    // R13: rf_en falls only after a finished word or on time-out
    p_rf_drop_r13: assert property (@(posedge clk) disable iff (rst)
        ($fell(rf_en) && !asleep) |-> $past(word_done));
endmodule

bind tx_session_ctrl tx_session_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .word_done(word_done), .rf_en(rf_en),
    .word_start(word_start), .word_abort(word_abort), .word_seed(word_seed),
    .word_func(word_func), .queue_bits(queue_bits), .time_bits(time_bits),
    .asleep(asleep)
);

// File: tb/tx_session_ctrl_tb.sv
module tx_session_ctrl_tb;
    localparam int UNIT = 16;
    localparam int WLEN = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        tick = 1;
    logic [3:0]  btn = 0;
    logic        word_done = 0;
    logic [1:0]  cfg_timeout = 0;
    logic [1:0]  cfg_min_words = 0;
    logic [1:0]  cfg_seed_mode = 0;
    logic        cfg_seed_alt = 0;
    logic [15:0] sync_cnt = 0;
    logic        rf_en, word_start, word_abort, word_seed, sync_inc, asleep;
    logic [3:0]  word_func;
    logic [1:0]  queue_bits, time_bits;

    tx_session_ctrl #(.UNIT_TICKS(UNIT), .QWIN_TICKS(40), .SAMPLE_TICKS(4)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .btn(btn), .word_done(word_done),
        .cfg_timeout(cfg_timeout), .cfg_min_words(cfg_min_words),
        .cfg_seed_mode(cfg_seed_mode), .cfg_seed_alt(cfg_seed_alt),
        .sync_cnt(sync_cnt), .rf_en(rf_en), .word_start(word_start),
        .word_abort(word_abort), .word_seed(word_seed), .word_func(word_func),
        .sync_inc(sync_inc), .queue_bits(queue_bits), .time_bits(time_bits),
        .asleep(asleep)
    );

    always #10 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    int n_start = 0, n_abort = 0, n_inc = 0, rf_err = 0, wcnt = 0;
    logic       last_seed = 0, first_seed = 0;
    logic [3:0] last_func = 0, first_func = 0;
    logic [1:0] last_queue = 0;
    int b_start, b_abort, b_inc;
    bit done = 0;

    // Serializer model and output monitor
    always @(negedge clk) begin
        if (rst) begin
            wcnt = 0;
            word_done = 0;
        end else begin
            if (sync_inc) n_inc++;
            if (word_abort) begin
                n_abort++;
                wcnt = 0;
            end
            if (word_start) begin
                if (n_start == b_start) begin
                    first_seed = word_seed;
                    first_func = word_func;
                end
                n_start++;
                last_seed = word_seed;
                last_func = word_func;
                last_queue = queue_bits;
                if (!rf_en) rf_err++;
                wcnt = WLEN;
                word_done = 0;
            end else begin
                word_done = (wcnt == 1);
                if (wcnt > 0) wcnt--;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mark();
        b_start = n_start;
        b_abort = n_abort;
        b_inc = n_inc;
    endtask

    task automatic press(input logic [3:0] b, input int hold, input int after);
        btn = b;
        cyc(hold);
        btn = 0;
        cyc(after);
    endtask

    typedef struct packed {
        logic        alt;
        logic [1:0]  mode;
        logic [15:0] sync;
        logic [3:0]  b;
        logic        exp_seed;
    } seed_vec_t;

    localparam seed_vec_t VEC [8] = '{
        '{1'b0, 2'b00, 16'h0000, 4'b0101, 1'b0},
        '{1'b0, 2'b10, 16'h0000, 4'b0101, 1'b1},
        '{1'b0, 2'b01, 16'h007F, 4'b0101, 1'b1},
        '{1'b0, 2'b01, 16'h0080, 4'b0101, 1'b0},
        '{1'b1, 2'b11, 16'h1234, 4'b1001, 1'b1},
        '{1'b1, 2'b11, 16'h0000, 4'b0101, 1'b0},
        '{1'b0, 2'b10, 16'h0000, 4'b0001, 1'b0},
        '{1'b0, 2'b11, 16'h0000, 4'b0010, 1'b0}
    };

    initial begin
        b_start = 0; b_abort = 0; b_inc = 0;
        cyc(3);
        // R1: reset state
        chk("R1 rf_en", rf_en, 0);
        chk("R1 word_start", word_start, 0);
        chk("R1 queue/time", {queue_bits, time_bits}, 0);
        chk("R1 asleep", asleep, 0);
        rst = 0;
        cyc(3);

        // R10 R12 R2: seed selection table
        foreach (VEC[i]) begin
            cfg_seed_alt = VEC[i].alt;
            cfg_seed_mode = VEC[i].mode;
            sync_cnt = VEC[i].sync;
            mark();
            press(VEC[i].b, 3, 150);
            chk("R12 seed kind", first_seed, VEC[i].exp_seed);
            chk("R10 function code", first_func, VEC[i].exp_seed ? 4'hF : VEC[i].b);
            chk("R2 sync_inc count", n_inc - b_inc, VEC[i].exp_seed ? 0 : 1);
            chk("R13 rf_en off", rf_en, 0);
        end
        cfg_seed_mode = 0;
        sync_cnt = 0;

        // R3: minimum words after release
        for (int m = 0; m < 4; m++) begin
            cfg_min_words = 2'(m);
            mark();
            press(4'b0010, 3, 200);
            chk("R3 words sent", n_start - b_start, 1 << m);
        end
        cfg_min_words = 0;

        // R4: one-unit time-out while held
        cfg_timeout = 2'b01;
        mark();
        btn = 4'b0001;
        cyc(40);
        chk("R4 asleep", asleep, 1);
        chk("R4 rf_en", rf_en, 0);
        chk("R4 starts", n_start - b_start, 2);
        chk("R4 aborts", n_abort - b_abort, 1);
        btn = 0;
        cyc(3);
        chk("R4 wake on release", asleep, 0);
        cyc(60);

        // R4: four-unit time-out
        cfg_timeout = 2'b10;
        mark();
        btn = 4'b0001;
        cyc(50);
        chk("R4 no early time-out", asleep, 0);
        cyc(50);
        chk("R4 four units", asleep, 1);
        btn = 0;
        cyc(60);

        // R4: no time-out when field is 00
        cfg_timeout = 2'b00;
        mark();
        btn = 4'b1000;
        cyc(100);
        chk("R4 none selected", rf_en, 1);
        chk("R4 none aborts", n_abort - b_abort, 0);
        btn = 0;
        cyc(100);

        // R5: time-out overrides minimum count
        cfg_timeout = 2'b01;
        cfg_min_words = 2'b11;
        mark();
        press(4'b0100, 3, 40);
        chk("R5 starts", n_start - b_start, 2);
        chk("R5 aborts", n_abort - b_abort, 1);
        chk("R5 rf_en", rf_en, 0);
        cfg_timeout = 0;
        cfg_min_words = 0;
        cyc(60);

        // R6: new button aborts and restarts
        mark();
        btn = 4'b0001;
        cyc(5);
        btn = 4'b0011;
        cyc(8);
        chk("R6 abort", n_abort - b_abort, 1);
        chk("R6 sync_inc", n_inc - b_inc, 2);
        chk("R6 new function", last_func, 4'b0011);
        chk("R6 queue", last_queue, 0);
        btn = 0;
        cyc(100);

        // R7: partial release has no effect
        mark();
        btn = 4'b0011;
        cyc(20);
        btn = 4'b0001;
        cyc(30);
        chk("R7 function kept", last_func, 4'b0011);
        chk("R7 no abort", n_abort - b_abort, 0);
        chk("R7 one activation", n_inc - b_inc, 1);
        btn = 0;
        cyc(100);

        // R8: repeat presses in the window
        press(4'b0100, 3, 20);
        chk("R8 first", last_queue, 0);
        press(4'b0100, 8, 20);
        chk("R8 second", last_queue, 1);
        press(4'b0100, 8, 20);
        chk("R8 third", last_queue, 2);
        press(4'b0100, 8, 20);
        chk("R8 fourth", last_queue, 3);
        press(4'b0100, 8, 20);
        chk("R8 saturate", last_queue, 3);
        press(4'b0010, 8, 100);
        chk("R8 other combo", last_queue, 0);
        press(4'b0010, 8, 100);
        chk("R8 after window", last_queue, 0);

        // R8: queued press during the final words
        cfg_min_words = 2'b10;
        press(4'b0100, 3, 15);
        mark();
        press(4'b0100, 3, 3);
        chk("R8 queued abort", n_abort - b_abort, 1);
        chk("R8 queued count", last_queue, 1);
        cfg_min_words = 0;
        cyc(200);

        // R9: duration field
        btn = 4'b0010;
        cyc(24);
        chk("R9 one unit", time_bits, 1);
        cyc(16);
        chk("R9 two units", time_bits, 2);
        cyc(50);
        chk("R9 saturate", time_bits, 3);
        btn = 0;
        cyc(100);

        // R11: delayed seed
        cfg_seed_mode = 2'b10;
        mark();
        btn = 4'b0001;
        cyc(60);
        chk("R11 first hopping", first_seed, 0);
        chk("R11 later seed", last_seed, 1);
        chk("R11 seed function", last_func, 4'hF);
        chk("R11 single inc", n_inc - b_inc, 1);
        btn = 0;
        cyc(100);
        cfg_seed_alt = 1;
        mark();
        btn = 4'b0011;
        cyc(85);
        chk("R11 alt delay", last_seed, 1);
        btn = 0;
        cyc(100);
        // R12: immediate-only mode blocks the delayed kind
        cfg_seed_alt = 0;
        cfg_seed_mode = 2'b11;
        btn = 4'b0001;
        cyc(60);
        chk("R12 no delayed seed", last_seed, 0);
        btn = 0;
        cyc(100);

        chk("R2 rf_en at every start", rf_err, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule